// File: doc/BRIEF.md
# Streaming Pairwise Group Merger

This block is a single stage of a cascaded merge sorter for signed 32-bit integers. It reads one input stream and treats it as a series of back-to-back sorted groups, each `GROUP` elements long. It takes the groups two at a time. The earlier group of each pair is copied into a small on-chip buffer. The later group is then consumed directly from the head of the input stream while the two are merged. Each pair produces one ascending run of `2*GROUP` elements on the output stream.

Both edges of the block use a valid/ready handshake. An element moves when valid and ready are both high on a rising clock edge. A cascade of stages with `GROUP` = 2, 4, 8 and so on, fed by a compare-swap front end, sorts a fixed-length run. Every stage pops exactly as many elements as it pushes, so neighbouring stages cannot deadlock.

Each pair is handled in two phases. In the fill phase the stage accepts one element per cycle and emits nothing. In the merge phase it emits one element per cycle unless the output is stalled, or unless a comparison has to wait for the input.

Top module: `msort_merge_stage`

## Requirements
- R1: During the fill phase, `in_ready` is high every cycle, and the first `GROUP` elements accepted for a pair are stored without producing any output.
- R2: The `2*GROUP` elements pushed for each pair are the pair's elements in ascending order under signed two's-complement comparison.
- R3: When the head of the buffered group equals the head of the input stream, the buffered element is emitted first, and `in_ready` is low in that cycle.
- R4: Once one group of a pair is exhausted, the rest of the other group is emitted in order. While only buffered elements remain, `in_ready` stays low even if `in_valid` is high.
- R5: Over each pair, the stage pops exactly `2*GROUP` elements from its input and pushes exactly `2*GROUP` elements to its output.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values, and the stage pops no input.
- R7: An element chosen in a merge cycle appears on `out_data` with `out_valid` high after the next rising edge. If the input stream is empty while both groups still hold elements, nothing new is emitted.
- R8: A synchronous active-high `rst` clears `out_valid`, the counters and the buffer. The next accepted element then starts the first group of a new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream element available |
| in_ready | output | 1 | Stage pops the head element this cycle |
| in_data | input | DATA_W | Head element of the upstream stream, signed |
| out_valid | output | 1 | Output register holds an element |
| out_ready | input | 1 | Downstream accepts the element this cycle |
| out_data | output | DATA_W | Element being pushed, signed |

## Verification
A buffer or counter that slips by one moves the pair boundary. The error then shows as an out-of-order or missing element within the next `2*GROUP` pushes. A pop-versus-push mismatch shows at the end of the stream, because the output never reaches the expected total. A wrong tie-break or drain decision shows at once on `in_ready`, in the same cycle as the comparison. A broken output register shows one cycle into a downstream stall, as a changed `out_data`.

// File: rtl/msort_pkg.sv
package msort_pkg;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_MERGE = 1'b1
    } msort_state_e;

endpackage

// File: rtl/msort_group_buf.sv
module msort_group_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/msort_pick.sv
module msort_pick #(
    parameter int DATA_W = 32
) (
    input  logic              a_has,
    input  logic              b_has,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic              take_a,
    output logic              take_b,
    output logic [DATA_W-1:0] pick_val
);

    logic a_le_b;

    always_comb begin
        // ties favour the buffered (earlier) group, keeping the merge stable
        a_le_b   = $signed(a_val) <= $signed(b_val);
        take_a   = a_has && (!b_has || (b_valid && a_le_b));
        take_b   = b_has && b_valid && (!a_has || !a_le_b);
        pick_val = take_a ? a_val : b_val;
    end

endmodule

// File: rtl/msort_merge_stage.sv
module msort_merge_stage
    import msort_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int GROUP  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int IDX_W = $clog2(GROUP);
    localparam int CNT_W = IDX_W + 1;
    localparam int PAIR  = 2 * GROUP;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GROUP);
    localparam logic [IDX_W-1:0] WR_LAST  = IDX_W'(GROUP - 1);

    typedef struct packed {
        msort_state_e      state;
        logic [IDX_W-1:0]  wr_idx;
        logic [CNT_W-1:0]  a_cnt;
        logic [CNT_W-1:0]  b_cnt;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
    } regs_t;

    regs_t r_q, r_d;

    logic              buf_we;
    logic [DATA_W-1:0] buf_head;
    logic              a_has, b_has, slot_free;
    logic              take_a, take_b;
    logic [DATA_W-1:0] pick_val;
    logic [CNT_W-1:0]  a_cnt_nx, b_cnt_nx;

    msort_group_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (GROUP)
    ) i_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_we),
        .wr_idx  (r_q.wr_idx),
        .wr_data (in_data),
        .rd_idx  (r_q.a_cnt[IDX_W-1:0]),
        .rd_data (buf_head)
    );

    msort_pick #(
        .DATA_W (DATA_W)
    ) i_pick (
        .a_has    (a_has),
        .b_has    (b_has),
        .b_valid  (in_valid),
        .a_val    (buf_head),
        .b_val    (in_data),
        .take_a   (take_a),
        .take_b   (take_b),
        .pick_val (pick_val)
    );

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        buf_we    = 1'b0;
        a_has     = (r_q.state == ST_MERGE) && (r_q.a_cnt != CNT_FULL);
        b_has     = (r_q.state == ST_MERGE) && (r_q.b_cnt != CNT_FULL);
        slot_free = !r_q.out_valid || out_ready;
        a_cnt_nx  = r_q.a_cnt + CNT_W'(take_a);
        b_cnt_nx  = r_q.b_cnt + CNT_W'(take_b);

        if (out_ready) begin
            r_d.out_valid = 1'b0;
        end

        unique case (r_q.state)
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_we     = 1'b1;
                    r_d.wr_idx = r_q.wr_idx + 1'b1;
                    if (r_q.wr_idx == WR_LAST) begin
                        r_d.state  = ST_MERGE;
                        r_d.wr_idx = '0;
                        r_d.a_cnt  = '0;
                        r_d.b_cnt  = '0;
                    end
                end
            end
            ST_MERGE: begin
                if (slot_free && (take_a || take_b)) begin
                    in_ready      = take_b;
                    r_d.out_valid = 1'b1;
                    r_d.out_data  = pick_val;
                    r_d.a_cnt     = a_cnt_nx;
                    r_d.b_cnt     = b_cnt_nx;
                    if (a_cnt_nx == CNT_FULL && b_cnt_nx == CNT_FULL) begin
                        r_d.state = ST_FILL;
                    end
                end
            end
            default: r_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_FILL, wr_idx: '0, a_cnt: '0, b_cnt: '0,
                     out_valid: 1'b0, out_data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.out_valid;
    assign out_data  = r_q.out_data;

    // checker state: pushes within the current pair and the last value pushed
    logic [CNT_W:0]    chk_push_q;
    logic [DATA_W-1:0] chk_last_q;
    logic              chk_push;

    assign chk_push = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_push_q <= '0;
            chk_last_q <= '0;
        end else if (chk_push) begin
            chk_last_q <= out_data;
            chk_push_q <= (chk_push_q == (CNT_W+1)'(PAIR - 1)) ? '0 : chk_push_q + 1'b1;
        end
    end

    a_r1_fill_ready: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_FILL) |-> in_ready);

    a_r2_sorted: assert property (@(posedge clk) disable iff (rst)
        (chk_push && chk_push_q != '0) |-> ($signed(out_data) >= $signed(chk_last_q)));

    a_r4_no_extra_pop: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_MERGE && r_q.b_cnt == CNT_FULL) |-> !in_ready);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r6_no_pop_when_full: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_MERGE && out_valid && !out_ready) |-> !in_ready);

    a_r8_reset: assert property (@(posedge clk)
        rst |=> (!out_valid && r_q.state == ST_FILL));

endmodule

// File: tb/test_msort_merge_stage.sv
module test_msort_merge_stage;

    localparam int DW = 32;
    localparam int G  = 4;
    localparam int NV = 5;
    localparam int VL = 2 * G;

    localparam int VEC_IN [NV][VL] = '{
        '{1, 3, 5, 7, 2, 4, 6, 8},
        '{10, 20, 30, 40, 1, 2, 3, 4},
        '{-5, -1, 0, 9, -7, -1, 2, 100},
        '{0, 0, 0, 1, 32'h80000000, 0, 2147483647, 2147483647},
        '{1, 2, 3, 4, 5, 6, 7, 8}
    };
    localparam int VEC_EXP [NV][VL] = '{
        '{1, 2, 3, 4, 5, 6, 7, 8},
        '{1, 2, 3, 4, 10, 20, 30, 40},
        '{-7, -5, -1, -1, 0, 2, 9, 100},
        '{32'h80000000, 0, 0, 0, 0, 1, 2147483647, 2147483647},
        '{1, 2, 3, 4, 5, 6, 7, 8}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;

    int total = 0;
    int fails = 0;
    int src [64];
    int exp_q [64];

    always #5 clk = ~clk;

    msort_merge_stage #(.DATA_W(DW), .GROUP(G)) i_msort_merge_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R8 out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);
    endtask

    task automatic drive(input bit v, input int d);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        #1;
    endtask

    task automatic run_stream(input int n, input bit gaps);
        int popped = 0;
        int pushed = 0;
        int cyc = 0;
        while (pushed < n) begin
            @(negedge clk);
            out_ready = gaps ? (cyc % 7 != 2) : 1'b1;
            in_valid  = (popped < n) && (gaps ? (cyc % 5 != 3) : 1'b1);
            in_data   = (popped < n) ? src[popped] : 0;
            #1;
            if (out_valid && out_ready) begin
                chk($signed(out_data) == exp_q[pushed], "R2 merged order",
                    $signed(out_data), exp_q[pushed]);
                pushed++;
            end
            if (in_valid && in_ready) popped++;
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        chk(popped == pushed, "R5 pops equal pushes", popped, pushed);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        do_reset();

        // R3: equal heads, buffered group goes first
        for (int i = 0; i < G; i++) begin
            drive(1'b1, 7);
            if (i == 0) chk(in_ready == 1'b1, "R1 fill accepts", in_ready, 1);
        end
        drive(1'b1, 7);
        chk(in_ready == 1'b0, "R3 tie keeps input", in_ready, 0);
        for (int i = 1; i < G; i++) drive(1'b1, 7);
        drive(1'b1, 7);
        chk(in_ready == 1'b1, "R4 tail of input group popped", in_ready, 1);
        for (int i = 1; i < G; i++) drive(1'b1, 7);

        // R4: input group exhausted first, buffered tail drains without pops
        for (int i = 0; i < G; i++) drive(1'b1, (i + 1) * 10);
        for (int i = 0; i < G; i++) begin
            drive(1'b1, i + 1);
            if (i == 0) chk(in_ready == 1'b1, "R2 smaller input head popped", in_ready, 1);
        end
        for (int i = 0; i < G; i++) begin
            drive(1'b1, 99);
            chk(in_ready == 1'b0, "R4 no pop while buffer drains", in_ready, 0);
        end
        drive(1'b0, 0);

        // R6 / R7: latency, hold under backpressure, input stall
        do_reset();
        for (int i = 0; i < G; i++) drive(1'b1, i + 1);
        drive(1'b1, 5);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk(out_valid == 1'b1 && out_data == 1, "R7 emitted next cycle", out_data, 1);
        chk(in_ready == 1'b0, "R6 no pop while output full", in_ready, 0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            #1;
            chk(out_valid == 1'b1 && out_data == 1, "R6 output held", out_data, 1);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R7 no emit while input empty", out_valid, 0);

        // R8: reset in mid merge, then a fresh pair
        do_reset();
        for (int i = 0; i < VL; i++) begin
            src[i] = VEC_IN[0][i];
            exp_q[i] = VEC_EXP[0][i];
        end
        run_stream(VL, 1'b0);

        // table walk, with and without stalls on both sides
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < VL; i++) begin
                src[v * VL + i]   = VEC_IN[v][i];
                exp_q[v * VL + i] = VEC_EXP[v][i];
            end
        end
        run_stream(NV * VL, 1'b1);
        run_stream(NV * VL, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule